// File: doc/BRIEF.md
# Clock-Generator Configuration Target on I2C

This block is the serial configuration port of a spread-spectrum clock generator. It is an I2C target that holds a small bank of byte-wide control registers. It accepts block writes and serves block reads. The register pointer advances by one after every data byte. Every transaction carries one extra byte-count byte immediately after the offset. On a write, the target acknowledges that byte and then discards it. On a read, the target sends a fixed count value before the first register byte.

Two register bits leave the block as decoded controls for the secondary clock synthesizer: a power enable and a 72/48 MHz frequency select. The full register contents are also exported to the rest of the chip. The primary synthesizer, the oscillator and this interface have no register control and keep running.

SCL and SDA arrive asynchronously and are oversampled by the system clock. SDA is driven open-drain: the target only ever pulls the line low.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset, the target releases SDA. The register values are offset 0 = 0x02, offset 1 = 0x00 and offset 2 = 0x00, so the secondary synthesizer is enabled and 72 MHz is selected.
- R2: The target ACKs (pulls SDA low in the ninth bit) an address byte whose upper seven bits equal the DEV_ADDR parameter. For any other address it NACKs. It then drives nothing and changes no register until the next START.
- R3: Write order is address with bit0 = 0, then offset N, then byte-count, then data. All bytes are ACKed. Data bytes are stored at N, N+1, … until STOP, whatever the byte-count value.
- R4: The register pointer wraps from BANK_SIZE-1 to 0, on writes and on reads alike.
- R5: Offsets from IMPL_REGS up to BANK_SIZE-1 are unimplemented. A write to such an offset is ACKed and changes no register. A read of such an offset returns 0x00.
- R6: After address-write, offset N, a repeated START and address with bit0 = 1, the target first sends COUNT_VAL. It then sends the registers from N onward, MSB first.
- R7: When the controller NACKs a byte during a read, the target stops driving SDA until the next START or STOP.
- R8: synth2_en_o equals bit 1 of offset 0, where 0 means powered down. synth2_sel48_o equals bit 7 of offset 1, where 0 selects 72 MHz and 1 selects 48 MHz.
- R9: The SDA drive changes only while SCL is low.
- R10: A START seen in the middle of a transfer (SDA falls while SCL is high) restarts address reception. The partial transfer leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain drive) |
| regs_o | output | 8*IMPL_REGS | Implemented registers, offset 0 in the low byte |
| synth2_en_o | output | 1 | Secondary synthesizer power enable |
| synth2_sel48_o | output | 1 | Secondary output select: 0 = 72 MHz, 1 = 48 MHz |

## Verification
A data-byte commit and the pointer wrap from the last offset back to zero fall on the same SCL rising edge. The same edge can also carry a write aimed at an unimplemented offset. The bench provokes these cases with bursts that start at every offset and have lengths from one to four, so many bursts cross the top of the bank. Each burst is judged by reading it back through the bus. The expected bytes come from modulo arithmetic on a bench-side copy of the bank, with unimplemented slots reading zero.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK_PREP, S_ACK, S_TX, S_MACK
  } xfer_st_t;

  typedef enum logic [1:0] {
    ROLE_ADDR, ROLE_OFS, ROLE_CNT, ROLE_DATA
  } byte_role_t;

  localparam int EN_BIT  = 1;  // offset 0
  localparam int SEL_BIT = 7;  // offset 1

  function automatic logic [7:0] reg_reset_val(input int unsigned idx);
    return (idx == 0) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

endpackage

// File: rtl/cfgi2c_linesync.sv
module cfgi2c_linesync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
  import cfgi2c_pkg::*;
#(
  parameter int IMPL_REGS = 3,
  parameter int PTR_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  logic [7:0]             wr_data,
  input  logic [PTR_W-1:0]       rd_ptr,
  output logic [7:0]             rd_data,
  output logic [IMPL_REGS*8-1:0] regs_flat
);
  logic [7:0] regs_q [IMPL_REGS];

  for (genvar g = 0; g < IMPL_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs_q[g] <= reg_reset_val(g);
      else if (wr_en && wr_ptr == PTR_W'(g))  regs_q[g] <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = regs_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < IMPL_REGS; i++)
      if (rd_ptr == PTR_W'(i)) rd_data = regs_q[i];
  end

  // R5: writes beyond the implemented registers leave the bank untouched
  p_unimpl_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(wr_ptr) >= IMPL_REGS) |=> $stable(regs_flat));
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         BANK_SIZE = 4,     // power of two
  parameter int         IMPL_REGS = 3,     // at least 2
  parameter logic [7:0] COUNT_VAL = 8'h04
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [IMPL_REGS*8-1:0] regs_o,
  output logic                   synth2_en_o,
  output logic                   synth2_sel48_o
);
  localparam int PTR_W = (BANK_SIZE > 1) ? $clog2(BANK_SIZE) : 1;
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(BANK_SIZE - 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  cfgi2c_linesync u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_s, .sda_s, .scl_rise, .scl_fall, .start_ev, .stop_ev
  );

  xfer_st_t   st;
  byte_role_t role;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic [PTR_W-1:0] ptr;
  logic tx_mode, tx_first, ack_ok, mack_ok, sda_oe_q;

  // named internal events
  logic       byte_done, data_wr, tx_load;
  logic [7:0] rx_byte, tx_byte, rd_data;

  assign rx_byte   = {shreg[6:0], sda_s};
  assign byte_done = (st == S_RX) && scl_rise && (bit_cnt == 3'd7);
  assign data_wr   = byte_done && (role == ROLE_DATA);
  assign tx_load   = scl_fall && tx_mode &&
                     ((st == S_ACK) || (st == S_MACK && mack_ok));
  assign tx_byte   = tx_first ? COUNT_VAL : rd_data;

  cfgi2c_regbank #(.IMPL_REGS(IMPL_REGS), .PTR_W(PTR_W)) u_bank (
    .clk, .rst_n,
    .wr_en(data_wr), .wr_ptr(ptr), .wr_data(rx_byte),
    .rd_ptr(ptr), .rd_data, .regs_flat(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  role <= ROLE_ADDR;  bit_cnt <= '0;  shreg <= '0;
      ptr <= '0;  tx_mode <= 1'b0;  tx_first <= 1'b0;
      ack_ok <= 1'b0;  mack_ok <= 1'b0;  sda_oe_q <= 1'b0;
    end else if (start_ev) begin
      st <= S_RX;  role <= ROLE_ADDR;  bit_cnt <= '0;
      tx_mode <= 1'b0;  sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      st <= S_IDLE;  tx_mode <= 1'b0;  sda_oe_q <= 1'b0;
    end else begin
      if (tx_load) begin
        st <= S_TX;  shreg <= tx_byte;  sda_oe_q <= ~tx_byte[7];
        bit_cnt <= '0;  tx_first <= 1'b0;
        if (!tx_first) ptr <= ptr_next(ptr);
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              st     <= S_ACK_PREP;
              ack_ok <= 1'b1;
              case (role)
                ROLE_ADDR: begin
                  ack_ok <= addr_hit(rx_byte, DEV_ADDR);
                  if (addr_hit(rx_byte, DEV_ADDR)) begin
                    if (rx_byte[0]) begin
                      tx_mode <= 1'b1;  tx_first <= 1'b1;
                    end else role <= ROLE_OFS;
                  end
                end
                ROLE_OFS: begin ptr <= rx_byte[PTR_W-1:0];  role <= ROLE_CNT; end
                ROLE_CNT:  role <= ROLE_DATA;
                ROLE_DATA: ptr <= ptr_next(ptr);
                default: ;
              endcase
            end
          end
          S_ACK_PREP: if (scl_fall) begin
            if (ack_ok) begin sda_oe_q <= 1'b1;  st <= S_ACK; end
            else st <= S_IDLE;
          end
          S_ACK: if (scl_fall) begin
            sda_oe_q <= 1'b0;  st <= S_RX;  bit_cnt <= '0;
          end
          S_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe_q <= 1'b0;  st <= S_MACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_oe_q <= ~shreg[6];
              bit_cnt  <= bit_cnt + 3'd1;
            end
          end
          S_MACK: begin
            if (scl_rise) mack_ok <= ~sda_s;
            if (scl_fall && !mack_ok) st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o       = sda_oe_q;
  assign synth2_en_o    = regs_o[EN_BIT];
  assign synth2_sel48_o = regs_o[8 + SEL_BIT];

  // R9: drive only moves while the synchronized clock line is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_q != $past(sda_oe_q)) |-> !scl_s);
  // R7: in idle (after NACK / stop) the line is never pulled
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_q);
  // R4: pointer wraps after the top offset
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr == PTR_TOP) |=> (ptr == '0));
  // R8: a write to offset 0 lands on the enable output
  p_en_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr == '0) |=> (synth2_en_o == $past(rx_byte[EN_BIT])));
  // R8: a write to offset 1 lands on the frequency select
  p_sel_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr == PTR_W'(1)) |=> (synth2_sel48_o == $past(rx_byte[SEL_BIT])));
  // R6: the count byte leads a read, MSB first
  p_count_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_first) |=> (sda_oe_q == ~COUNT_VAL[7]));
  // R2: a refused address leaves the line free
  p_nack_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK_PREP && scl_fall && !ack_ok) |=> !sda_oe_q);
endmodule

// File: tb/cfg_i2c_target_tb_top.sv
`timescale 1ns/1ps
module cfg_i2c_target_tb_top;
  localparam logic [6:0] ADDR = 7'h5A;
  localparam int BANK = 4;
  localparam int IMPL = 3;
  localparam logic [7:0] CNT = 8'hA5;
  localparam int QT = 60;  // quarter SCL period in ns

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [IMPL*8-1:0] regs;
  logic en, sel;
  wire  sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  cfg_i2c_target #(.DEV_ADDR(ADDR), .BANK_SIZE(BANK), .IMPL_REGS(IMPL),
                   .COUNT_VAL(CNT)) dut_i (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .regs_o(regs), .synth2_en_o(en), .synth2_sel48_o(sel)
  );

  int vecs = 0, fails = 0, r9_viol = 0;
  bit done = 0;
  logic [7:0] model [BANK];

  // R9 monitor: drive must not move while SCL is high
  always @(sda_oe) if (rst_n && scl_m) r9_viol++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    #QT sda_m = 1'b0; #QT scl_m = 1'b0;
  endtask
  task automatic i2c_rstart();
    #QT sda_m = 1'b1; #QT scl_m = 1'b1; #QT sda_m = 1'b0; #QT scl_m = 1'b0;
  endtask
  task automatic i2c_stop();
    #QT sda_m = 1'b0; #QT scl_m = 1'b1; #QT sda_m = 1'b1; #QT;
  endtask
  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      #QT sda_m = b[i]; #QT scl_m = 1'b1; #(2*QT) scl_m = 1'b0;
    end
    #QT sda_m = 1'b1; #QT scl_m = 1'b1; #QT ack = sda_line; #QT scl_m = 1'b0;
  endtask
  task automatic rb(input logic nack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      #QT sda_m = 1'b1; #QT scl_m = 1'b1; #QT b = {b[6:0], sda_line}; #QT scl_m = 1'b0;
    end
    #QT sda_m = nack; #QT scl_m = 1'b1; #(2*QT) scl_m = 1'b0;
  endtask

  function automatic logic [IMPL*8-1:0] model_flat();
    logic [IMPL*8-1:0] f;
    for (int i = 0; i < IMPL; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check_regs(input string req);
    #1;
    chk(regs == model_flat(), req, int'(regs), int'(model_flat()));
    chk(en == model[0][1], "R8 enable", int'(en), int'(model[0][1]));
    chk(sel == model[1][7], "R8 select", int'(sel), int'(model[1][7]));
  endtask

  task automatic burst_write(input int s, input int len, input logic [7:0] cntb,
                             input logic [7:0] d [4]);
    logic a;
    int p;
    i2c_start();
    wb({ADDR, 1'b0}, a); chk(a == 1'b0, "R2 addr ack", int'(a), 0);
    wb(8'(s), a);        chk(a == 1'b0, "R3 offset ack", int'(a), 0);
    wb(cntb, a);         chk(a == 1'b0, "R3 count ack", int'(a), 0);
    p = s;
    for (int i = 0; i < len; i++) begin
      wb(d[i], a); chk(a == 1'b0, "R3/R5 data ack", int'(a), 0);
      if (p < IMPL) model[p] = d[i];
      p = (p + 1) % BANK;  // R4 wrap
    end
    i2c_stop();
  endtask

  task automatic burst_read(input int s, input int len);
    logic a;
    logic [7:0] b;
    int p;
    i2c_start();
    wb({ADDR, 1'b0}, a); chk(a == 1'b0, "R6 addr ack", int'(a), 0);
    wb(8'(s), a);        chk(a == 1'b0, "R6 offset ack", int'(a), 0);
    i2c_rstart();
    wb({ADDR, 1'b1}, a); chk(a == 1'b0, "R6 read addr ack", int'(a), 0);
    rb(1'b0, b);         chk(b == CNT, "R6 count byte", int'(b), int'(CNT));
    p = s;
    for (int i = 0; i < len; i++) begin
      rb(i == len - 1, b);
      chk(b == ((p < IMPL) ? model[p] : 8'h00), "R6/R4/R5 read data",
          int'(b), int'((p < IMPL) ? model[p] : 8'h00));
      p = (p + 1) % BANK;
    end
    rb(1'b1, b); chk(b == 8'hFF, "R7 released after NACK", int'(b), 8'hFF);
    i2c_stop();
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] d [4];
    model[0] = 8'h02; model[1] = 8'h00; model[2] = 8'h00; model[3] = 8'h00;
    #33 rst_n = 1'b1;
    #20;
    chk(sda_oe == 1'b0, "R1 SDA released", int'(sda_oe), 0);
    check_regs("R1 reset values");

    // sweep every start offset and burst length; count byte is unrelated to length
    for (int s = 0; s < BANK; s++)
      for (int len = 1; len <= 4; len++) begin
        for (int i = 0; i < 4; i++) d[i] = 8'(s * 53 + len * 29 + i * 71 + 7);
        burst_write(s, len, 8'(9 - 2 * len), d);
        check_regs("R3/R4/R5 bank after burst");
        burst_read(s, len + 1);
      end

    // explicit decode: power down and pick 48 MHz
    d[0] = 8'h00; d[1] = 8'h80; d[2] = 8'h11; d[3] = 8'h00;
    burst_write(0, 2, 8'h01, d);
    check_regs("R8 decode after write");
    chk(en == 1'b0 && sel == 1'b1, "R8 power down and 48 MHz", int'({en, sel}), 1);

    // wrong address: NACK, bytes ignored
    i2c_start();
    wb({ADDR ^ 7'h01, 1'b0}, a); chk(a == 1'b1, "R2 foreign addr NACK", int'(a), 1);
    wb(8'h00, a); chk(a == 1'b1, "R2 ignored byte", int'(a), 1);
    wb(8'h03, a); chk(a == 1'b1, "R2 ignored byte", int'(a), 1);
    wb(8'hFF, a); chk(a == 1'b1, "R2 ignored byte", int'(a), 1);
    i2c_stop();
    check_regs("R2 bank unchanged");

    // mid-transfer START restarts the address phase
    i2c_start();
    wb({ADDR, 1'b0}, a); wb(8'h00, a);
    i2c_rstart();
    wb({ADDR, 1'b0}, a); chk(a == 1'b0, "R10 addr after restart", int'(a), 0);
    wb(8'h02, a); wb(8'h05, a); wb(8'h77, a);
    chk(a == 1'b0, "R10 data ack", int'(a), 0);
    i2c_stop();
    model[2] = 8'h77;
    check_regs("R10 only new transfer applied");

    chk(r9_viol == 0, "R9 drive moved while SCL high", r9_viol, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule